// File: doc/BRIEF.md
# SMBus Register-Read Command Bridge

This block is the transaction layer of an SMBus slave. It lets an outside host read 32-bit internal registers in two steps. First, the host sends a block-write. That write carries a command code and four bytes that name the target. The bridge then raises a request on a simple internal port and holds it until a response arrives or a millisecond timeout expires. It then stores a packed status byte and the returned dword. Later, the host writes the command code, issues a repeated start and reads back a block. That block is a count of five, the status byte and the four data bytes, most significant first. When PEC is enabled, a PEC byte supplied by the front-end follows the data.

The bridge works on byte-level events from a front-end that handles SCL/SDA. These events are start or repeated start, stop, a received byte (with the front-end's PEC match flag) and the master's ACK or NACK after each byte the slave sends. The bridge answers each received byte with a combinational ACK decision. While an internal request is pending it asks the front-end to stretch the clock.

Two state machines do the work. The protocol machine walks through `P_IDLE`, `P_ADDR`, `P_CMD`, `P_CNT`, `P_PAY`, `P_PEC`, `P_SEND` and `P_DONE`:
- A stop in any state returns it to `P_IDLE`. A start in any state moves it to `P_ADDR`.
- From `P_ADDR`, a matching write address goes to `P_CMD`. A matching read address goes to `P_SEND`, but only if the previous start came in `P_CNT`. Anything else goes to `P_DONE`.
- A valid command moves `P_CMD` to `P_CNT`. A count of four moves `P_CNT` to `P_PAY`.
- The fourth payload byte goes to `P_PEC` or, without PEC, launches the request and goes to `P_DONE`. A PEC byte always goes to `P_DONE` and launches the request only when it matches.
- `P_SEND` goes to `P_DONE` on a master NACK or after the last byte.

The execution machine has two states. It goes from `E_IDLE` to `E_BUSY` on a launch. It returns to `E_IDLE` on a response or on the timeout tick.

Top module: `smb_rrb_bridge`

## Requirements
- R1: A first byte after a start is ACKed only when its upper seven bits equal {1,1,strap[3],0,strap[2:0]}. Any other address is NACKed and the rest of the transfer is ignored.
- R2: A write transfer that is ACKed through command 8'hD2 or 8'hF2, count 4 and four payload bytes launches one request. The request has req_mem=1 for 8'hF2 and 0 for 8'hD2, req_sel=first payload byte and req_off={second, third, fourth}.
- R3: Any command byte other than 8'hD2 and 8'hF2 is NACKed and launches no request.
- R4: A count byte other than 4 is NACKed and launches no request.
- R5: With pec_en=1, the request launches only after a PEC byte flagged as matching. A mismatching PEC byte is NACKed, launches nothing and leaves the stored status and data unchanged.
- R6: req_valid and stretch stay high, with steady request fields, from launch until a response or the timeout. No new launch happens while busy.
- R7: A response stores status bit5=master abort, bit4=target abort and bit0=1 only when neither abort is set. Bits 6 and 3:1 read zero. The response data is stored.
- R8: If the TIMEOUT_MS-th ms_tick arrives with no response, the request drops, the status becomes 8'h80 and the data becomes 0. A later response is ignored.
- R9: A read transfer (matching write address, valid command, repeated start, matching read address) returns 8'h05, the status, then data[31:24], [23:16], [15:8] and [7:0]. The byte tx_pec follows when pec_en=1.
- R10: After the master NACKs a sent byte, or after the last byte, tx_drive falls and further master ACKs have no effect.
- R11: After reset, and until the first completion, a read returns status 8'h00 and data 0.
- R12: A read address that does not follow a valid command and a repeated start is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_addr | input | 4 | Variable bits of the slave address |
| pec_en | input | 1 | PEC byte expected and sent |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rx_start | input | 1 | Start or repeated start seen |
| rx_stop | input | 1 | Stop seen |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_pec_ok | input | 1 | Received byte equals the running PEC |
| rx_ack | output | 1 | ACK decision for the byte in this cycle |
| tx_data | output | 8 | Byte to send next |
| tx_drive | output | 1 | Slave owns the read data phase |
| tx_mack | input | 1 | Master ACKed the sent byte |
| tx_mnack | input | 1 | Master NACKed the sent byte |
| tx_pec | input | 8 | PEC value to send last |
| stretch | output | 1 | Hold the bus clock low |
| req_valid | output | 1 | Internal read request pending |
| req_mem | output | 1 | 1 for a memory read, 0 for a configuration read |
| req_sel | output | 8 | Bus number or destination selector |
| req_off | output | 24 | Device/function with register number, or address offset |
| rsp_valid | input | 1 | Internal response valid |
| rsp_data | input | 32 | Response data |
| rsp_mabort | input | 1 | Response ended in master abort |
| rsp_tabort | input | 1 | Response ended in target abort |

## Verification
A protocol state that is off by one position shows up at once in the next ACK decision: a command or count byte is ACKed that should be NACKed, or the reverse. In a read, it shows up as a misplaced byte in the read sequence. A fault in the execution machine shows up within two cycles of the final payload byte as a missing or stuck req_valid or stretch. A fault in the stored status or data shows up only at the next read transfer, so each completion is followed by a full read back. The sweeps over all 2048 address/strap pairs and all 256 command and count codes catch any decode error.

// File: rtl/smb_rrb_pkg.sv
`timescale 1ns/1ps
package smb_rrb_pkg;
    localparam int          DATA_W     = 32;
    localparam logic [7:0]  CMD_CFG_RD = 8'hD2;
    localparam logic [7:0]  CMD_MEM_RD = 8'hF2;
    localparam logic [7:0]  WR_COUNT   = 8'd4;
    localparam logic [7:0]  RD_COUNT   = 8'd5;

    typedef enum logic [3:0] {
        P_IDLE, P_ADDR, P_CMD, P_CNT, P_PAY, P_PEC, P_SEND, P_DONE
    } proto_st_t;

    typedef enum logic {E_IDLE, E_BUSY} exec_st_t;

    typedef struct packed {
        logic        is_mem;
        logic [7:0]  sel;
        logic [23:0] off;
    } rd_req_t;
endpackage

// File: rtl/smb_rrb_proto.sv
`timescale 1ns/1ps
module smb_rrb_proto
    import smb_rrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        strap_addr,
    input  logic              pec_en,
    input  logic              rx_start,
    input  logic              rx_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_pec_ok,
    output logic              rx_ack,
    input  logic              tx_mack,
    input  logic              tx_mnack,
    input  logic [7:0]        tx_pec,
    output logic [7:0]        tx_data,
    output logic              tx_drive,
    input  logic [7:0]        stat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              launch_o,
    output rd_req_t           req_o
);
    proto_st_t       st_q, st_n;
    logic [2:0]      idx_q;
    logic            armed_q;
    logic            cmd_mem_q;
    logic [3:0][7:0] pay_q;
    logic            launch_q;
    logic            go;
    logic            addr_hit;
    logic            cmd_ok;
    logic [2:0]      last_idx;

    assign addr_hit = (rx_data[7:1] == {2'b11, strap_addr[3], 1'b0, strap_addr[2:0]});
    assign cmd_ok   = (rx_data == CMD_CFG_RD) || (rx_data == CMD_MEM_RD);
    assign last_idx = pec_en ? 3'd6 : 3'd5;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= P_IDLE;
            idx_q     <= '0;
            armed_q   <= 1'b0;
            cmd_mem_q <= 1'b0;
            pay_q     <= '0;
            launch_q  <= 1'b0;
        end else begin
            st_q     <= st_n;
            launch_q <= go;
            if (rx_start)
                armed_q <= (st_q == P_CNT);
            else if (rx_stop)
                armed_q <= 1'b0;
            if (st_n != st_q)
                idx_q <= '0;
            else if ((st_q == P_PAY && rx_valid) || (st_q == P_SEND && tx_mack))
                idx_q <= idx_q + 3'd1;
            if (st_q == P_PAY && rx_valid)
                pay_q[idx_q[1:0]] <= rx_data;
            if (st_q == P_CMD && rx_valid)
                cmd_mem_q <= (rx_data == CMD_MEM_RD);
        end
    end

    // next state and outputs
    always_comb begin
        st_n   = st_q;
        rx_ack = 1'b0;
        go     = 1'b0;
        if (rx_stop)
            st_n = P_IDLE;
        else if (rx_start)
            st_n = P_ADDR;
        else unique case (st_q)
            P_IDLE: ;
            P_ADDR: if (rx_valid) begin
                if (addr_hit && !rx_data[0]) begin
                    rx_ack = 1'b1;
                    st_n   = P_CMD;
                end else if (addr_hit && rx_data[0] && armed_q) begin
                    rx_ack = 1'b1;
                    st_n   = P_SEND;
                end else
                    st_n = P_DONE;
            end
            P_CMD: if (rx_valid) begin
                rx_ack = cmd_ok;
                st_n   = cmd_ok ? P_CNT : P_DONE;
            end
            P_CNT: if (rx_valid) begin
                rx_ack = (rx_data == WR_COUNT);
                st_n   = (rx_data == WR_COUNT) ? P_PAY : P_DONE;
            end
            P_PAY: if (rx_valid) begin
                rx_ack = 1'b1;
                if (idx_q == 3'd3) begin
                    if (pec_en)
                        st_n = P_PEC;
                    else begin
                        go   = 1'b1;
                        st_n = P_DONE;
                    end
                end
            end
            P_PEC: if (rx_valid) begin
                rx_ack = rx_pec_ok;
                go     = rx_pec_ok;
                st_n   = P_DONE;
            end
            P_SEND: begin
                if (tx_mnack)
                    st_n = P_DONE;
                else if (tx_mack && idx_q == last_idx)
                    st_n = P_DONE;
            end
            P_DONE: ;
            default: st_n = P_IDLE;
        endcase
    end

    always_comb begin
        tx_data = 8'hFF;
        if (st_q == P_SEND) begin
            unique case (idx_q)
                3'd0:    tx_data = RD_COUNT;
                3'd1:    tx_data = stat_i;
                3'd2:    tx_data = data_i[31:24];
                3'd3:    tx_data = data_i[23:16];
                3'd4:    tx_data = data_i[15:8];
                3'd5:    tx_data = data_i[7:0];
                3'd6:    tx_data = tx_pec;
                default: tx_data = 8'hFF;
            endcase
        end
    end

    assign tx_drive = (st_q == P_SEND);
    assign launch_o = launch_q;
    assign req_o    = '{is_mem: cmd_mem_q, sel: pay_q[0], off: {pay_q[1], pay_q[2], pay_q[3]}};

    AST_NACK_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> !launch_q); // R4
    AST_RELEASE_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_drive && tx_mnack) |=> !tx_drive); // R10
    AST_READ_NEEDS_RBIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_drive) |-> $past(rx_valid && rx_data[0] && rx_ack)); // R12
endmodule

// File: rtl/smb_rrb_exec.sv
`timescale 1ns/1ps
module smb_rrb_exec
    import smb_rrb_pkg::*;
#(
    parameter int TIMEOUT_MS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              launch,
    input  rd_req_t           req_in,
    output logic              busy,
    output rd_req_t           req_out,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_mabort,
    input  logic              rsp_tabort,
    output logic [7:0]        stat_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int            CW       = $clog2(TIMEOUT_MS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_MS - 1);

    exec_st_t          st_q, st_n;
    logic [CW-1:0]     cnt_q;
    logic              fin_ok, fin_to;
    rd_req_t           req_q;
    logic [7:0]        stat_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n   = st_q;
        fin_ok = 1'b0;
        fin_to = 1'b0;
        unique case (st_q)
            E_IDLE: if (launch) st_n = E_BUSY;
            E_BUSY: begin
                if (rsp_valid) begin
                    st_n   = E_IDLE;
                    fin_ok = 1'b1;
                end else if (ms_tick && cnt_q == CNT_LAST) begin
                    st_n   = E_IDLE;
                    fin_to = 1'b1;
                end
            end
            default: st_n = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            req_q  <= '0;
            stat_q <= '0;
            data_q <= '0;
        end else begin
            if (st_q == E_IDLE && launch) begin
                req_q <= req_in;
                cnt_q <= '0;
            end else if (st_q == E_BUSY && ms_tick)
                cnt_q <= cnt_q + 1'b1;
            if (fin_ok) begin
                stat_q <= {2'b00, rsp_mabort, rsp_tabort, 3'b000, ~(rsp_mabort | rsp_tabort)};
                data_q <= rsp_data;
            end else if (fin_to) begin
                stat_q <= 8'h80;
                data_q <= '0;
            end
        end
    end

    assign busy    = (st_q == E_BUSY);
    assign req_out = req_q;
    assign stat_o  = stat_q;
    assign data_o  = data_q;

    AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_valid && !ms_tick) |=> (busy && $stable(req_q))); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[6] == 1'b0 && stat_q[3:1] == 3'b000)); // R7
    AST_SUCCESS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[0] |-> (stat_q[7:4] == 4'b0000)); // R7
    AST_TIMEOUT_CLEARS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[7] |-> (data_q == '0)); // R8
endmodule

// File: rtl/smb_rrb_bridge.sv
`timescale 1ns/1ps
module smb_rrb_bridge
    import smb_rrb_pkg::*;
#(
    parameter int TIMEOUT_MS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  strap_addr,
    input  logic        pec_en,
    input  logic        ms_tick,
    input  logic        rx_start,
    input  logic        rx_stop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_pec_ok,
    output logic        rx_ack,
    output logic [7:0]  tx_data,
    output logic        tx_drive,
    input  logic        tx_mack,
    input  logic        tx_mnack,
    input  logic [7:0]  tx_pec,
    output logic        stretch,
    output logic        req_valid,
    output logic        req_mem,
    output logic [7:0]  req_sel,
    output logic [23:0] req_off,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_data,
    input  logic        rsp_mabort,
    input  logic        rsp_tabort
);
    logic              launch;
    logic              busy;
    rd_req_t           req_new, req_cur;
    logic [7:0]        stat;
    logic [DATA_W-1:0] data;

    smb_rrb_proto u_proto (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .pec_en(pec_en),
        .rx_start(rx_start), .rx_stop(rx_stop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_pec_ok(rx_pec_ok), .rx_ack(rx_ack),
        .tx_mack(tx_mack), .tx_mnack(tx_mnack), .tx_pec(tx_pec),
        .tx_data(tx_data), .tx_drive(tx_drive),
        .stat_i(stat), .data_i(data), .launch_o(launch), .req_o(req_new)
    );

    smb_rrb_exec #(.TIMEOUT_MS(TIMEOUT_MS)) u_exec (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .launch(launch),
        .req_in(req_new), .busy(busy), .req_out(req_cur),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_mabort(rsp_mabort), .rsp_tabort(rsp_tabort),
        .stat_o(stat), .data_o(data)
    );

    assign stretch   = launch | busy;
    assign req_valid = busy;
    assign req_mem   = req_cur.is_mem;
    assign req_sel   = req_cur.sel;
    assign req_off   = req_cur.off;
endmodule

// File: tb/smb_rrb_bridge_bench.sv
`timescale 1ns/1ps
module smb_rrb_bridge_bench;
    localparam int TMO = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, pec_en, ms_tick, rx_start, rx_stop, rx_valid, rx_pec_ok;
    logic [3:0]  strap_addr;
    logic [7:0]  rx_data, tx_data, tx_pec, req_sel;
    logic        rx_ack, tx_drive, tx_mack, tx_mnack, stretch, req_valid, req_mem;
    logic [23:0] req_off;
    logic        rsp_valid, rsp_mabort, rsp_tabort;
    logic [31:0] rsp_data;

    smb_rrb_bridge #(.TIMEOUT_MS(TMO)) u_smb_rrb_bridge (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .pec_en(pec_en),
        .ms_tick(ms_tick), .rx_start(rx_start), .rx_stop(rx_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pec_ok(rx_pec_ok),
        .rx_ack(rx_ack), .tx_data(tx_data), .tx_drive(tx_drive),
        .tx_mack(tx_mack), .tx_mnack(tx_mnack), .tx_pec(tx_pec),
        .stretch(stretch), .req_valid(req_valid), .req_mem(req_mem),
        .req_sel(req_sel), .req_off(req_off), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_mabort(rsp_mabort), .rsp_tabort(rsp_tabort)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] dev(input logic [3:0] s);
        return {2'b11, s[3], 1'b0, s[2:0]};
    endfunction

    function automatic logic [7:0] exp_stat(input logic mab, input logic tab);
        return {2'b00, mab, tab, 3'b000, ~(mab | tab)};
    endfunction

    task automatic do_start();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); rx_stop = 1'b1;
        @(negedge clk); rx_stop = 1'b0;
    endtask

    task automatic send_b(input logic [7:0] b, input logic pok, output logic ack);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_pec_ok = pok;
        #2 ack = rx_ack;
        @(negedge clk);
        rx_valid = 1'b0; rx_pec_ok = 1'b0;
    endtask

    task automatic post(input logic [7:0] cmd, input logic [31:0] pl, input logic pec_good,
                        output logic ok, output logic pec_ack);
        logic a;
        ok = 1'b1;
        pec_ack = 1'b0;
        do_start();
        send_b({dev(strap_addr), 1'b0}, 1'b0, a); ok &= a;
        send_b(cmd, 1'b0, a);                     ok &= a;
        send_b(8'd4, 1'b0, a);                    ok &= a;
        for (int i = 3; i >= 0; i--) begin
            send_b(pl[i*8 +: 8], 1'b0, a);        ok &= a;
        end
        if (pec_en) send_b(8'h5A, pec_good, pec_ack);
        do_stop();
    endtask

    task automatic serve(input string tag, input logic mem, input logic [31:0] pl,
                         input logic [31:0] rd, input logic mab, input logic tab);
        for (int i = 0; i < 20 && !req_valid; i++) @(negedge clk);
        chk({tag, " R2 req_valid"}, {31'd0, req_valid}, 32'd1);
        chk({tag, " R2 req_mem"}, {31'd0, req_mem}, {31'd0, mem});
        chk({tag, " R2 req_sel"}, {24'd0, req_sel}, {24'd0, pl[31:24]});
        chk({tag, " R2 req_off"}, {8'd0, req_off}, {8'd0, pl[23:0]});
        chk({tag, " R6 stretch busy"}, {31'd0, stretch}, 32'd1);
        rsp_valid = 1'b1; rsp_data = rd; rsp_mabort = mab; rsp_tabort = tab;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_mabort = 1'b0; rsp_tabort = 1'b0;
        chk({tag, " R6 req dropped"}, {31'd0, req_valid}, 32'd0);
        chk({tag, " R6 stretch dropped"}, {31'd0, stretch}, 32'd0);
    endtask

    task automatic read_back(input string tag, input int nack_at,
                             output logic [7:0] st, output logic [31:0] d);
        logic a;
        logic [7:0] b [7];
        int n;
        n = pec_en ? 7 : 6;
        for (int i = 0; i < 7; i++) b[i] = 8'h00;
        do_start();
        send_b({dev(strap_addr), 1'b0}, 1'b0, a);
        send_b(8'hD2, 1'b0, a);
        do_start();
        send_b({dev(strap_addr), 1'b1}, 1'b0, a);
        chk({tag, " R9 read addr ack"}, {31'd0, a}, 32'd1);
        for (int i = 0; i < n; i++) begin
            b[i] = tx_data;
            chk({tag, " R9 drive"}, {31'd0, tx_drive}, 32'd1);
            if (i == n - 1 || i == nack_at) tx_mnack = 1'b1;
            else tx_mack = 1'b1;
            @(negedge clk);
            tx_mnack = 1'b0; tx_mack = 1'b0;
            if (i == nack_at) break;
        end
        chk({tag, " R10 released"}, {31'd0, tx_drive}, 32'd0);
        tx_mack = 1'b1;
        @(negedge clk);
        tx_mack = 1'b0;
        chk({tag, " R10 extra ack ignored"}, {31'd0, tx_drive}, 32'd0);
        do_stop();
        if (nack_at < 0) begin
            chk({tag, " R9 count byte"}, {24'd0, b[0]}, 32'd5);
            if (pec_en) chk({tag, " R9 pec byte"}, {24'd0, b[6]}, {24'd0, tx_pec});
        end
        st = b[1];
        d  = {b[2], b[3], b[4], b[5]};
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic a, ok, pa;
        logic [7:0]  st;
        logic [31:0] d, pl, rd;
        rst_n = 1'b0; pec_en = 1'b0; ms_tick = 1'b0; rx_start = 1'b0; rx_stop = 1'b0;
        rx_valid = 1'b0; rx_pec_ok = 1'b0; rx_data = 8'h00; strap_addr = 4'b1010;
        tx_mack = 1'b0; tx_mnack = 1'b0; tx_pec = 8'h3C;
        rsp_valid = 1'b0; rsp_data = '0; rsp_mabort = 1'b0; rsp_tabort = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 req_valid reset", {31'd0, req_valid}, 32'd0);
        chk("R11 stretch reset", {31'd0, stretch}, 32'd0);
        chk("R11 tx_drive reset", {31'd0, tx_drive}, 32'd0);
        read_back("R11 first", -1, st, d);
        chk("R11 status before completion", {24'd0, st}, 32'h00);
        chk("R11 data before completion", d, 32'h0);

        // R12 read address without armed command
        do_start();
        send_b({dev(strap_addr), 1'b1}, 1'b0, a);
        chk("R12 bare read nacked", {31'd0, a}, 32'd0);
        chk("R12 no drive", {31'd0, tx_drive}, 32'd0);
        do_stop();

        // R1 address/strap sweep
        for (int s = 0; s < 16; s++) begin
            strap_addr = 4'(s);
            for (int ad = 0; ad < 128; ad++) begin
                do_start();
                send_b({7'(ad), 1'b0}, 1'b0, a);
                chk("R1 address match", {31'd0, a},
                    {31'd0, (ad[6:5] == 2'b11 && ad[4] == s[3] && ad[3] == 1'b0 && ad[2:0] == s[2:0])});
                do_stop();
            end
            chk("R1 no request from address", {31'd0, req_valid}, 32'd0);
        end
        strap_addr = 4'b1010;

        // R3 command sweep
        for (int c = 0; c < 256; c++) begin
            do_start();
            send_b({dev(strap_addr), 1'b0}, 1'b0, a);
            send_b(8'(c), 1'b0, a);
            chk("R3 command ack", {31'd0, a}, {31'd0, (c == 8'hD2 || c == 8'hF2)});
            do_stop();
            chk("R3 no request", {31'd0, stretch}, 32'd0);
        end

        // R4 count sweep
        for (int c = 0; c < 256; c++) begin
            do_start();
            send_b({dev(strap_addr), 1'b0}, 1'b0, a);
            send_b(8'hF2, 1'b0, a);
            send_b(8'(c), 1'b0, a);
            chk("R4 count ack", {31'd0, a}, {31'd0, (c == 4)});
            do_stop();
            chk("R4 no request", {31'd0, stretch}, 32'd0);
        end
        read_back("R3 R4 after sweeps", -1, st, d);
        chk("R3 status untouched", {24'd0, st}, 32'h00);

        // R2 R7 R9 patterns with all abort combinations
        for (int k = 0; k < 8; k++) begin
            pl = {8'(k * 17 + 3), 8'(k * 29), 8'(255 - k * 7), 8'(k * 41 + 5)};
            rd = 32'hA500_0000 ^ (32'(k) * 32'h0103_0507);
            post(k[0] ? 8'hF2 : 8'hD2, pl, 1'b1, ok, pa);
            chk("R2 write acked", {31'd0, ok}, 32'd1);
            serve("R2 pattern", k[0], pl, rd, k[1], k[2]);
            read_back("R9 pattern", -1, st, d);
            chk("R7 status", {24'd0, st}, {24'd0, exp_stat(k[1], k[2])});
            chk("R7 data", d, rd);
        end

        // R6 request held across cycles and sub-timeout ticks
        pl = 32'h1234_5678;
        post(8'hD2, pl, 1'b1, ok, pa);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R6 held valid", {31'd0, req_valid}, 32'd1);
            chk("R6 held off", {8'd0, req_off}, {8'd0, pl[23:0]});
        end
        for (int i = 0; i < TMO - 1; i++) tick();
        chk("R6 held after ticks", {31'd0, req_valid}, 32'd1);
        serve("R6", 1'b0, pl, 32'hDEAD_BEEF, 1'b0, 1'b0);

        // R8 timeout
        post(8'hF2, 32'h0F00_0001, 1'b1, ok, pa);
        for (int i = 0; i < 4 && !req_valid; i++) @(negedge clk);
        for (int i = 0; i < TMO; i++) begin
            chk("R8 pending before last tick", {31'd0, req_valid}, 32'd1);
            tick();
        end
        chk("R8 dropped on timeout", {31'd0, req_valid}, 32'd0);
        chk("R8 stretch off", {31'd0, stretch}, 32'd0);
        rsp_valid = 1'b1; rsp_data = 32'h7777_7777;
        @(negedge clk);
        rsp_valid = 1'b0;
        read_back("R8", -1, st, d);
        chk("R8 timeout status", {24'd0, st}, 32'h80);
        chk("R8 timeout data", d, 32'h0);

        // R5 PEC handling
        pec_en = 1'b1;
        post(8'hD2, 32'h0102_0304, 1'b1, ok, pa);
        chk("R5 good pec acked", {31'd0, pa}, 32'd1);
        serve("R5 good", 1'b0, 32'h0102_0304, 32'h1122_3344, 1'b0, 1'b0);
        read_back("R5 good", -1, st, d);
        chk("R5 status good", {24'd0, st}, 32'h01);
        chk("R5 data good", d, 32'h1122_3344);
        post(8'hF2, 32'h0506_0708, 1'b0, ok, pa);
        chk("R5 bad pec nacked", {31'd0, pa}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R5 bad pec no request", {31'd0, stretch}, 32'd0);
        read_back("R5 bad", -1, st, d);
        chk("R5 status kept", {24'd0, st}, 32'h01);
        chk("R5 data kept", d, 32'h1122_3344);
        pec_en = 1'b0;

        // R10 early NACK
        read_back("R10 early nack", 2, st, d);
        chk("R10 status before nack", {24'd0, st}, 32'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule